// File: doc/BRIEF.md
# DMA Channel Interrupt Status and Mask Unit

This unit gathers the per-channel completion, abort and fault event pulses from up to eight DMA channels. It holds them in a single 32-bit flag register. Each event class has its own byte lane. Software reads the flag register, and it clears individual flags by writing ones to them. A separate mask register holds three disable bits for each channel, one for each event class. A combined interrupt line is raised whenever a flag is set and its mask bit is clear. The masks only gate the interrupt line. The flags themselves are always recorded.

The same register port also carries a write-only abort register. Writing a channel bitmask to it sends a one-cycle abort request to every selected channel at the same time. A per-channel "ongoing" vector reports which channels have no flag of any class pending. Software uses it as the "still running" answer to a status query.

Top module: `dma_irq_hub`

## Requirements
- R1: After reset the flag register reads 0, the mask register reads all used mask bits set (0x00FFFFFF for 8 channels), `irq` is 0, `abort_req` is 0 and every `chan_ongoing` bit is 1.
- R2: A pulse on `ev_err[i]`, `ev_abort[i]` or `ev_done[i]` sets flag bit i, 8+i or 16+i respectively at the next rising clock edge. The flag remains set until it is cleared.
- R3: A write to address 0 clears every flag bit for which the write data bit is 1. Flag bits written with 0 keep their value.
- R4: When an event and a clearing write hit the same flag bit in the same cycle, the bit ends up set.
- R5: Flags are set regardless of the corresponding mask bit.
- R6: `irq` is 1 exactly when some flag bit is 1 while the mask bit at the same position is 0.
- R7: The mask register at address 1 uses the same lane layout as the flags: bit i masks fault, bit 8+i masks abort and bit 16+i masks completion. A write replaces the whole register. A mask bit of 1 disables that interrupt source.
- R8: A write to address 2 drives `abort_req` with data bits [NCH-1:0] for exactly the following cycle, and then returns it to 0. Address 2 reads as 0.
- R9: `chan_ongoing[i]` is 1 exactly when none of flag bits i, 8+i and 16+i is set.
- R10: Bits of lanes for channels at index NCH and above, and bits 31:24, always read 0. Address 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_err | input | NCH | Per-channel fault event pulses |
| ev_abort | input | NCH | Per-channel abort event pulses |
| ev_done | input | NCH | Per-channel completion (terminal count) pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 flags, 1 mask, 2 abort |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data of the selected register |
| abort_req | output | NCH | One-cycle abort request per channel |
| chan_ongoing | output | NCH | High when a channel has no flag pending |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The hardware event set and the software write-one clear can both reach one flag bit in the same clock. The bench provokes this on purpose by pulsing an event on a bit and clearing that same bit in the same cycle. The random phase also mixes event pulses with clears drawn from the currently set flags, so such collisions happen often. A reference model in the bench applies the set-wins rule. Every cycle it compares the read-back flags, `irq` and `chan_ongoing` with the model.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int LANE_W = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int NLANES = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_FLAGS = 2'd0,
    ADDR_MASK  = 2'd1,
    ADDR_ABORT = 2'd2,
    ADDR_NONE  = 2'd3
  } reg_addr_e;

  // bits that hold state for a given channel count
  function automatic logic [DATA_W-1:0] used_bits(input int nch);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int l = 0; l < NLANES; l++)
      for (int c = 0; c < nch; c++)
        m[l*LANE_W + c] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import dma_irq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] flags_o
);
  localparam logic [DATA_W-1:0] USED = used_bits(NCH);

  logic [DATA_W-1:0] flags_q, flags_d;
  logic              upd;

  // next state: a set dominates a clear on the same bit
  always_comb begin
    flags_d = (set_i | (flags_q & ~clr_i)) & USED;
    upd     = |((set_i | clr_i) & USED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags_q <= '0;
    else if (upd) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_i & USED)) |=> ((flags_q & $past(set_i & USED)) == $past(set_i & USED)));
  // R3
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i & USED)) |=> ((flags_q & $past(clr_i & ~set_i & USED)) == '0));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i == '0) && (clr_i == '0)) |=> $stable(flags_q));
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import dma_irq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] mask_o
);
  localparam logic [DATA_W-1:0] USED = used_bits(NCH);

  logic [DATA_W-1:0] mask_q, mask_d;

  always_comb mask_d = data_i & USED;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= USED;
    else if (wr_i) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // R7
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (mask_q == $past(data_i & USED)));
  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mask_q));
endmodule

// File: rtl/irq_abort_pulse.sv
module irq_abort_pulse #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_i,
  input  logic [NCH-1:0] sel_i,
  output logic [NCH-1:0] abort_o
);
  logic [NCH-1:0] abort_q, abort_d;

  always_comb abort_d = wr_i ? sel_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) abort_q <= '0;
    else        abort_q <= abort_d;
  end

  assign abort_o = abort_q;

  // R8
  abort_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (abort_q == $past(sel_i)));
  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> (abort_q == '0));
endmodule

// File: rtl/dma_irq_hub.sv
module dma_irq_hub
  import dma_irq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ev_err,
  input  logic [NCH-1:0]    ev_abort,
  input  logic [NCH-1:0]    ev_done,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCH-1:0]    abort_req,
  output logic [NCH-1:0]    chan_ongoing,
  output logic              irq
);
  localparam int ERR_LO = 0;
  localparam int ABT_LO = LANE_W;
  localparam int TC_LO  = 2 * LANE_W;

  logic              rst_n_s;
  logic [DATA_W-1:0] set_w, clr_w, flags, mask;
  logic              wr_flags, wr_mask, wr_abort;

  irq_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s));

  // write decode
  always_comb begin
    wr_flags = wr_en && (reg_addr_e'(wr_addr) == ADDR_FLAGS);
    wr_mask  = wr_en && (reg_addr_e'(wr_addr) == ADDR_MASK);
    wr_abort = wr_en && (reg_addr_e'(wr_addr) == ADDR_ABORT);
    clr_w    = wr_flags ? wr_data : '0;
  end

  // event lanes
  always_comb begin
    set_w = '0;
    for (int c = 0; c < NCH; c++) begin
      set_w[ERR_LO + c] = ev_err[c];
      set_w[ABT_LO + c] = ev_abort[c];
      set_w[TC_LO + c]  = ev_done[c];
    end
  end

  irq_flag_bank #(.NCH(NCH)) u_flags (
    .clk(clk), .rst_n(rst_n_s), .set_i(set_w), .clr_i(clr_w), .flags_o(flags));

  irq_mask_bank #(.NCH(NCH)) u_mask (
    .clk(clk), .rst_n(rst_n_s), .wr_i(wr_mask), .data_i(wr_data), .mask_o(mask));

  irq_abort_pulse #(.NCH(NCH)) u_abort (
    .clk(clk), .rst_n(rst_n_s), .wr_i(wr_abort), .sel_i(wr_data[NCH-1:0]),
    .abort_o(abort_req));

  // per-channel pending summary
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign chan_ongoing[c] = ~(flags[ERR_LO + c] | flags[ABT_LO + c] | flags[TC_LO + c]);
  end

  assign irq = |(flags & ~mask);

  // read mux
  always_comb begin
    unique case (reg_addr_e'(rd_addr))
      ADDR_FLAGS: rd_data = flags;
      ADDR_MASK:  rd_data = mask;
      default:    rd_data = '0;
    endcase
  end

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq |-> (flags != '0));
  // R9
  all_ongoing_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (flags == '0) |-> (&chan_ongoing));
  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_addr_e'(rd_addr) == ADDR_NONE) |-> (rd_data == '0));
  // R5
  masked_set_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (|(set_w & mask)) |=> (|flags));
endmodule

// File: tb/dma_irq_hub_test.sv
module dma_irq_hub_test;
  localparam int NCH = 8;
  localparam logic [31:0] USED = 32'h00FF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  ev_err, ev_abort, ev_done;
  logic        wr_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [7:0]  abort_req, chan_ongoing;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] m_flags, m_mask;
  logic [7:0]  m_abort;

  always #4 clk = ~clk;

  dma_irq_hub #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .ev_err(ev_err), .ev_abort(ev_abort), .ev_done(ev_done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .abort_req(abort_req), .chan_ongoing(chan_ongoing), .irq(irq));

  function automatic logic f_irq(input logic [31:0] f, input logic [31:0] m);
    return |(f & ~m);
  endfunction

  function automatic logic [7:0] f_ongoing(input logic [31:0] f);
    return ~(f[7:0] | f[15:8] | f[23:16]);
  endfunction

  function automatic logic [31:0] f_read(input logic [1:0] a);
    case (a)
      2'd0:    return m_flags;
      2'd1:    return m_mask;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] e, input logic [7:0] a, input logic [7:0] t,
                      input logic we, input logic [1:0] wa, input logic [31:0] wd,
                      input logic [1:0] ra, input string tag);
    logic [31:0] s, c;
    @(negedge clk);
    ev_err = e; ev_abort = a; ev_done = t;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    @(posedge clk);
    s = {8'h0, t, a, e};
    c = (we && wa == 2'd0) ? wd : 32'h0;
    m_flags = (s | (m_flags & ~c)) & USED;
    if (we && wa == 2'd1) m_mask = wd & USED;
    m_abort = (we && wa == 2'd2) ? wd[7:0] : 8'h0;
    #2;
    chk(rd_data, f_read(ra), {tag, " rd_data"});
    chk({31'h0, irq}, {31'h0, f_irq(m_flags, m_mask)}, {tag, " R6 irq"});
    chk({24'h0, chan_ongoing}, {24'h0, f_ongoing(m_flags)}, {tag, " R9 ongoing"});
    chk({24'h0, abort_req}, {24'h0, m_abort}, {tag, " R8 abort_req"});
  endtask

  task automatic idle_read(input logic [1:0] ra, input string tag);
    step(8'h0, 8'h0, 8'h0, 1'b0, 2'd0, 32'h0, ra, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0;
    ev_err = '0; ev_abort = '0; ev_done = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    m_flags = 32'h0; m_mask = USED; m_abort = 8'h0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    idle_read(2'd0, "R1 reset flags");
    idle_read(2'd1, "R1 reset mask");
    chk({31'h0, irq}, 32'h0, "R1 irq low");

    // R2 each lane, R5 set while masked
    step(8'h01, 8'h00, 8'h00, 1'b0, 2'd0, 32'h0, 2'd0, "R2 R5 err lane");
    step(8'h00, 8'h02, 8'h00, 1'b0, 2'd0, 32'h0, 2'd0, "R2 abort lane");
    step(8'h00, 8'h00, 8'h80, 1'b0, 2'd0, 32'h0, 2'd0, "R2 done lane");
    chk(rd_data, 32'h0080_0201, "R5 masked flags recorded");

    // R7 unmask only abort of ch1 -> irq
    step(8'h0, 8'h0, 8'h0, 1'b1, 2'd1, 32'hFFFF_FDFF, 2'd1, "R7 R6 unmask");
    chk({31'h0, irq}, 32'h1, "R6 irq raised");

    // R3 write zero no effect, then clear one bit
    step(8'h0, 8'h0, 8'h0, 1'b1, 2'd0, 32'h0, 2'd0, "R3 write zero");
    step(8'h0, 8'h0, 8'h0, 1'b1, 2'd0, 32'h0000_0200, 2'd0, "R3 clear abort1");
    chk({31'h0, irq}, 32'h0, "R6 irq dropped");

    // R4 set and clear same bit same cycle
    step(8'h08, 8'h0, 8'h0, 1'b1, 2'd0, 32'h0000_0008, 2'd0, "R4 set wins");
    chk(rd_data & 32'h8, 32'h8, "R4 bit3 stays set");

    // R8 multi-channel abort pulse
    step(8'h0, 8'h0, 8'h0, 1'b1, 2'd2, 32'hFFFF_FFA5, 2'd2, "R8 abort write");
    chk({24'h0, abort_req}, 32'hA5, "R8 abort bitmask");
    idle_read(2'd2, "R8 pulse ends");

    // R10 unmapped address
    step(8'h0, 8'h0, 8'h0, 1'b1, 2'd3, 32'hFFFF_FFFF, 2'd3, "R10 unmapped write");
    idle_read(2'd0, "R10 flags unchanged");
    idle_read(2'd1, "R10 mask unchanged");
    step(8'h0, 8'h0, 8'h0, 1'b1, 2'd1, 32'hFFFF_FFFF, 2'd1, "R10 upper mask bits");
    chk(rd_data, 32'h00FF_FFFF, "R10 mask upper zero");

    // R9 clear all then every channel ongoing
    step(8'h0, 8'h0, 8'h0, 1'b1, 2'd0, 32'hFFFF_FFFF, 2'd0, "R9 clear all");
    chk({24'h0, chan_ongoing}, 32'hFF, "R9 all ongoing");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0]  e, a, t;
      logic        we;
      logic [1:0]  wa;
      logic [31:0] wd;
      e  = ($urandom % 4 == 0) ? 8'($urandom) : 8'h0;
      a  = ($urandom % 5 == 0) ? 8'($urandom) : 8'h0;
      t  = ($urandom % 4 == 0) ? 8'($urandom) : 8'h0;
      we = ($urandom % 3 == 0);
      wa = 2'($urandom);
      wd = ($urandom % 2 == 0) ? (m_flags & $urandom) : $urandom;
      step(e, a, t, we, wa, wd, 2'($urandom), "R2 R3 R4 R6 R7 R8 random");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule